// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that fall inside a graphics aperture window onto physical addresses. The first translation level is a 64-entry on-chip directory. Software fills it by writing a 32-bit word that carries the entry number inside it. The second level is a set of 1024-entry page tables held in external memory. The block reads one 32-bit entry at a time through a request/response memory port. Each directory entry covers 4 MB of aperture. A two-bit size code picks a window of 256, 128, 64 or 32 MB, which enables 64, 32, 16 or 8 directory entries.

A four-entry fully associative cache keeps recent successful translations. It is emptied only when a control write sets bit 7 where the previous control write left it clear. The usual sequence is 0x2200 followed by 0x2280. A request ends in a physical address or a fault. Only one table walk runs at a time, and the request port drops its ready signal while a walk is in progress.

The walker has three states. IDLE accepts requests. It answers a fault or a cache hit directly, and takes the transition IDLE→ISSUE on a miss to a present directory entry. ISSUE drives the single memory read, then moves ISSUE→WAIT. WAIT holds until the memory response arrives and then takes WAIT→IDLE, producing the translated address or a fault.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_rd_valid`=0. Every directory entry is absent, the cache is empty, the aperture base is 0 and the size code is 0.
- R2: A configuration write with `cfg_addr`=0 loads a directory entry from `cfg_wdata`. Bits 5:0 give the entry index, bit 8 the present flag, bits 11:9 a 3-bit attribute and bits 31:12 the table page base. Bits 7:6 are ignored.
- R3: A directory write with bit 8 clear marks the indexed entry absent. A later request through that entry, if not cached, faults without any memory read.
- R4: `cfg_addr`=2 sets the aperture base from bits 31:22. `cfg_addr`=3 sets the size code from bits 1:0, where 0=256 MB, 1=128 MB, 2=64 MB and 3=32 MB. A request below the base, or at or beyond base plus size, faults without a memory read.
- R5: The directory index is `req_addr[31:22]` minus the base's bits 31:22. The memory read address is {table base, `req_addr[21:12]`, 2'b00}. `mem_rd_attr` carries the entry's attribute.
- R6: A fetched entry with bit 0 set gives `rsp_paddr` = {entry[31:12], `req_addr[11:0]`}. An entry with bit 0 clear (including zero) gives a fault.
- R7: A fault or a cache hit answers with `rsp_valid` in the cycle after acceptance. On a walk, `mem_rd_valid` is high for exactly the cycle after acceptance, and the answer comes in the cycle after `mem_resp_valid`.
- R8: `req_ready` is low from the cycle after a miss is accepted until the memory response is taken.
- R9: Successful walk results are cached, and a repeated page needs no memory read. Faults are not cached. The cache holds 4 pages with round-robin replacement, so the fifth distinct page evicts the first one filled.
- R10: A control write (`cfg_addr`=1) empties the cache only when bit 7 goes from 0 to 1 relative to the previous control write. Writing 0x2200 then 0x2280 flushes, and repeating 0x2280 does not.
- R11: A cached translation stays in use after its directory entry changes, until a flush. The window check still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 directory, 1 control, 2 base, 3 size |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Bus address to translate |
| req_ready | output | 1 | Request accepted when high |
| rsp_valid | output | 1 | Answer strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 32 | Physical address |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rd_attr | output | 3 | Attribute of the table page read |
| mem_resp_valid | input | 1 | Read data strobe |
| mem_resp_data | input | 32 | Table entry read |

## Verification
The bench uses the default 64 directory entries and 4 cache ways. With 4 ways, five distinct pages are enough to show the round-robin eviction order. With 64 entries, the 256 MB size code reaches entry 16. That entry lies outside the 64 MB window, so the same address can be shown to fault under one size code and walk under another. The memory model answers two cycles after each read and returns an entry computed from the read address. Some addresses yield invalid entries, which exercises the faulting path of the walk.

// File: rtl/xl_pkg.sv
package xl_pkg;
    localparam int VA_W   = 32;
    localparam int PG_W   = 12;
    localparam int L2_W   = 10;
    localparam int PN_W   = VA_W - PG_W;
    localparam int BASE_W = VA_W - PG_W - L2_W;
    localparam int ATTR_W = 3;

    localparam logic [1:0] CFG_DIR  = 2'd0;
    localparam logic [1:0] CFG_CTRL = 2'd1;
    localparam logic [1:0] CFG_BASE = 2'd2;
    localparam logic [1:0] CFG_SIZE = 2'd3;

    typedef struct packed {
        logic              present;
        logic [ATTR_W-1:0] attr;
        logic [PN_W-1:0]   tbl;
    } dir_ent_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } wstate_t;
endpackage

// File: rtl/ap_dir.sv
module ap_dir
    import xl_pkg::*;
#(
    parameter int DIR_N = 64,
    localparam int DIR_W = $clog2(DIR_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VA_W-1:0]  wr_word,
    input  logic [DIR_W-1:0] rd_idx,
    output dir_ent_t         rd_ent
);
    dir_ent_t ent_q [DIR_N];
    logic     rsvd_unused;

    assign rsvd_unused = ^wr_word[7:6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DIR_N; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_word[DIR_W-1:0]] <= '{present: wr_word[8],
                                           attr:    wr_word[11:9],
                                           tbl:     wr_word[VA_W-1:PG_W]};
        end
    end

    assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/ap_tlb.sv
module ap_tlb
    import xl_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PN_W-1:0] look_vpn,
    output logic            hit,
    output logic [PN_W-1:0] hit_ppn,
    input  logic            fill,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_ppn
);
    logic [WAYS-1:0]  vld_q;
    logic [WAYS-1:0]  match;
    logic [PN_W-1:0]  vpn_q [WAYS];
    logic [PN_W-1:0]  ppn_q [WAYS];
    logic [PTR_W-1:0] ptr_q;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = vld_q[w] && (vpn_q[w] == look_vpn);
        end
    endgenerate

    always_comb begin
        hit_ppn = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_ppn = hit_ppn | ppn_q[w];
        end
    end
    assign hit = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int w = 0; w < WAYS; w++) begin
                vpn_q[w] <= '0;
                ppn_q[w] <= '0;
            end
        end else if (flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill) begin
            vld_q[ptr_q] <= 1'b1;
            vpn_q[ptr_q] <= fill_vpn;
            ppn_q[ptr_q] <= fill_ppn;
            ptr_q <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
endmodule

// File: rtl/ap_walk.sv
module ap_walk
    import xl_pkg::*;
#(
    parameter int DIR_N = 64,
    localparam int DIR_W = $clog2(DIR_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_hi,
    input  logic [1:0]        size_sel,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [DIR_W-1:0]  dir_idx,
    input  dir_ent_t          dir_ent,
    input  logic              tlb_hit,
    input  logic [PN_W-1:0]   tlb_ppn,
    output logic              tlb_fill,
    output logic [PN_W-1:0]   fill_vpn,
    output logic [PN_W-1:0]   fill_ppn,
    output logic              mem_rd_valid,
    output logic [VA_W-1:0]   mem_rd_addr,
    output logic [ATTR_W-1:0] mem_rd_attr,
    input  logic              mem_resp_valid,
    input  logic [VA_W-1:0]   mem_resp_data
);
    localparam logic [BASE_W-1:0] DIR_CNT_MAX = BASE_W'(DIR_N);

    wstate_t             st_q, st_d;
    logic [BASE_W-1:0]   off_hi, dir_cnt;
    logic                in_win, accept, go_walk, resp_take;
    logic [VA_W-1:0]     va_q;
    logic [PN_W-1:0]     tbl_q;
    logic [ATTR_W-1:0]   attr_q;
    logic                resp_unused;

    assign resp_unused = ^mem_resp_data[PG_W-1:1];

    always_comb begin
        off_hi    = req_addr[VA_W-1 -: BASE_W] - base_hi;
        dir_cnt   = DIR_CNT_MAX >> size_sel;
        in_win    = (req_addr[VA_W-1 -: BASE_W] >= base_hi) && (off_hi < dir_cnt);
        dir_idx   = off_hi[DIR_W-1:0];
        accept    = (st_q == W_IDLE) && req_valid;
        go_walk   = accept && in_win && !tlb_hit && dir_ent.present;
        resp_take = (st_q == W_WAIT) && mem_resp_valid;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE:  if (go_walk) st_d = W_ISSUE;
            W_ISSUE: st_d = W_WAIT;
            W_WAIT:  if (mem_resp_valid) st_d = W_IDLE;
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
            va_q      <= '0;
            tbl_q     <= '0;
            attr_q    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && !go_walk) begin
                rsp_valid <= 1'b1;
                rsp_fault <= !(in_win && tlb_hit);
                rsp_paddr <= (in_win && tlb_hit) ? {tlb_ppn, req_addr[PG_W-1:0]} : '0;
            end
            if (go_walk) begin
                va_q   <= req_addr;
                tbl_q  <= dir_ent.tbl;
                attr_q <= dir_ent.attr;
            end
            if (resp_take) begin
                rsp_valid <= 1'b1;
                rsp_fault <= !mem_resp_data[0];
                rsp_paddr <= mem_resp_data[0] ?
                             {mem_resp_data[VA_W-1:PG_W], va_q[PG_W-1:0]} : '0;
            end
        end
    end

    always_comb begin
        req_ready    = (st_q == W_IDLE);
        mem_rd_valid = (st_q == W_ISSUE);
        mem_rd_addr  = {tbl_q, va_q[PG_W+L2_W-1:PG_W], 2'b00};
        mem_rd_attr  = attr_q;
        tlb_fill     = resp_take && mem_resp_data[0];
        fill_vpn     = va_q[VA_W-1:PG_W];
        fill_ppn     = mem_resp_data[VA_W-1:PG_W];
    end

    a_r7_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);
    a_r8_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);
    a_r7_answer_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        resp_take |=> rsp_valid);
    a_r6_fault_not_filled: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_fill |=> (rsp_valid && !rsp_fault));
endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
    import xl_pkg::*;
#(
    parameter int DIR_N    = 64,
    parameter int TLB_WAYS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    output logic [2:0]  mem_rd_attr,
    input  logic        mem_resp_valid,
    input  logic [31:0] mem_resp_data
);
    localparam int DIR_W = $clog2(DIR_N);

    logic [BASE_W-1:0] base_hi_q;
    logic [1:0]        size_q;
    logic              ctrl7_q;
    logic              flush;
    logic [DIR_W-1:0]  dir_idx;
    dir_ent_t          dir_ent;
    logic              tlb_hit, tlb_fill;
    logic [PN_W-1:0]   tlb_ppn, fill_vpn, fill_ppn;

    assign flush = cfg_we && (cfg_addr == CFG_CTRL) && cfg_wdata[7] && !ctrl7_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi_q <= '0;
            size_q    <= '0;
            ctrl7_q   <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_BASE) base_hi_q <= cfg_wdata[VA_W-1 -: BASE_W];
            if (cfg_addr == CFG_SIZE) size_q    <= cfg_wdata[1:0];
            if (cfg_addr == CFG_CTRL) ctrl7_q   <= cfg_wdata[7];
        end
    end

    ap_dir #(.DIR_N(DIR_N)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && (cfg_addr == CFG_DIR)),
        .wr_word (cfg_wdata),
        .rd_idx  (dir_idx),
        .rd_ent  (dir_ent)
    );

    ap_tlb #(.WAYS(TLB_WAYS)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_vpn (req_addr[VA_W-1:PG_W]),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .fill     (tlb_fill),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn)
    );

    ap_walk #(.DIR_N(DIR_N)) u_walk (
        .clk            (clk),
        .rst_n          (rst_n),
        .base_hi        (base_hi_q),
        .size_sel       (size_q),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_paddr      (rsp_paddr),
        .dir_idx        (dir_idx),
        .dir_ent        (dir_ent),
        .tlb_hit        (tlb_hit),
        .tlb_ppn        (tlb_ppn),
        .tlb_fill       (tlb_fill),
        .fill_vpn       (fill_vpn),
        .fill_ppn       (fill_ppn),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_attr    (mem_rd_attr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );
endmodule

// File: tb/aperture_xlate_tb.sv
module aperture_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [31:0] rsp_paddr, mem_rd_addr;
    logic [2:0]  mem_rd_attr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    bit done    = 0;
    logic [31:0] last_rd_addr = '0;
    logic [2:0]  last_rd_attr = '0;

    logic [19:0] m_tbl  [64];
    logic [2:0]  m_attr [64];
    logic [9:0]  m_base = '0;

    always #4 clk = ~clk;

    aperture_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_attr(mem_rd_attr), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[5:2] == 4'hF) return 32'h0;
        return {a[21:2] ^ 20'hC0000, 12'h001};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: answers two cycles after each read request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) begin
                rd_cnt++;
                last_rd_addr = mem_rd_addr;
                last_rd_attr = mem_rd_attr;
                @(negedge clk);
                mem_resp_valid = 1'b1;
                mem_resp_data  = mem_word(last_rd_addr);
                @(negedge clk);
                mem_resp_valid = 1'b0;
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic dir_wr(input int idx, input logic [19:0] tbl, input logic [2:0] attr,
                          input bit pres, input logic [1:0] rsvd);
        cfg_wr(2'd0, {tbl, attr, pres, rsvd, 6'(idx)});
        if (pres) begin
            m_tbl[idx] = tbl;
            m_attr[idx] = attr;
        end
    endtask

    task automatic xlate(input logic [31:0] va, input bit ef, input bit ew, input string req);
        int cyc, n0;
        logic [9:0] off;
        logic [31:0] ta, pte, ep;
        off = va[31:22] - m_base;
        ta  = {m_tbl[off[5:0]], va[21:12], 2'b00};
        pte = mem_word(ta);
        ep  = {pte[31:12], va[11:0]};
        @(negedge clk);
        chk(req_ready == 1'b1, {req, " ready before request"}, 32'(req_ready), 32'd1);
        n0 = rd_cnt;
        req_valid = 1'b1; req_addr = va;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 30) begin
            chk(req_ready == 1'b0, {req, " R8 stall during walk"}, 32'(req_ready), 32'd0);
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid == 1'b1, {req, " response seen"}, 32'(rsp_valid), 32'd1);
        chk(cyc == (ew ? 3 : 1), {req, " R7 latency"}, 32'(cyc), ew ? 32'd3 : 32'd1);
        chk(rd_cnt - n0 == int'(ew), {req, " R9 memory reads"}, 32'(rd_cnt - n0), 32'(ew));
        chk(rsp_fault == ef, {req, " fault flag"}, 32'(rsp_fault), 32'(ef));
        if (!ef) chk(rsp_paddr == ep, {req, " R6 physical address"}, rsp_paddr, ep);
        if (ew) begin
            chk(last_rd_addr == ta, {req, " R5 table read address"}, last_rd_addr, ta);
            chk(last_rd_attr == m_attr[off[5:0]], {req, " R5 attribute"},
                32'(last_rd_attr), 32'(m_attr[off[5:0]]));
        end
    endtask

    // {address, expected fault, expected walk}; base 0x4000_0000, 64 MB window
    localparam logic [33:0] VEC [10] = '{
        {32'h4000_0123, 1'b0, 1'b1},
        {32'h4000_0ABC, 1'b0, 1'b0},
        {32'h4040_1004, 1'b0, 1'b1},
        {32'h4080_0000, 1'b1, 1'b0},
        {32'h3FFF_F000, 1'b1, 1'b0},
        {32'h4400_0000, 1'b1, 1'b0},
        {32'h43FF_F010, 1'b1, 1'b1},
        {32'h43FF_F010, 1'b1, 1'b1},
        {32'h4000_5000, 1'b0, 1'b1},
        {32'h4040_1FFF, 1'b0, 1'b0}
    };

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_tbl[i] = '0;
            m_attr[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 no response in reset", 32'(rsp_valid), 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 no read in reset", 32'(mem_rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
        xlate(32'h0000_1000, 1'b1, 1'b0, "R1 empty directory");

        // programming: base, size code 2 (64 MB), directory entries
        cfg_wr(2'd2, 32'h4000_0000);
        m_base = 10'h100;
        cfg_wr(2'd3, 32'd2);
        dir_wr(0,  20'h10000, 3'd3, 1'b1, 2'b00);
        dir_wr(1,  20'h10001, 3'd0, 1'b1, 2'b00);
        dir_wr(15, 20'h1000F, 3'd0, 1'b1, 2'b00);
        dir_wr(16, 20'h10010, 3'd0, 1'b1, 2'b00);

        for (int i = 0; i < 10; i++)
            xlate(VEC[i][33:2], VEC[i][1], VEC[i][0], "R4 R5 R6 table vector");

        // R9: round-robin eviction (slots hold 0x40000,0x40401,0x40005)
        xlate(32'h4000_6000, 1'b0, 1'b1, "R9 fill fourth way");
        xlate(32'h4000_7000, 1'b0, 1'b1, "R9 fifth page evicts first");
        xlate(32'h4040_1000, 1'b0, 1'b0, "R9 second page kept");
        xlate(32'h4000_0000, 1'b0, 1'b1, "R9 evicted page walks again");
        xlate(32'h4000_5000, 1'b0, 1'b0, "R9 third page kept");

        // R3 and R11: invalidate directory entry 0
        dir_wr(0, 20'h0, 3'd0, 1'b0, 2'b00);
        xlate(32'h4000_5000, 1'b0, 1'b0, "R11 cached page survives directory change");
        xlate(32'h4000_8000, 1'b1, 1'b0, "R3 absent entry faults");

        // R10: flush on 0->1 of bit 7 only
        cfg_wr(2'd1, 32'h0000_2280);
        xlate(32'h4040_1000, 1'b0, 1'b1, "R10 first rising write flushes");
        cfg_wr(2'd1, 32'h0000_2280);
        xlate(32'h4040_1000, 1'b0, 1'b0, "R10 repeated write keeps cache");
        cfg_wr(2'd1, 32'h0000_2200);
        xlate(32'h4040_1000, 1'b0, 1'b0, "R10 clearing write keeps cache");
        cfg_wr(2'd1, 32'h0000_2280);
        xlate(32'h4040_1000, 1'b0, 1'b1, "R10 toggle sequence flushes");

        // R4: size code changes
        cfg_wr(2'd3, 32'd3);
        xlate(32'h43FF_F010, 1'b1, 1'b0, "R4 32 MB window excludes entry 15");
        xlate(32'h4200_0000, 1'b1, 1'b0, "R4 32 MB window upper edge");
        cfg_wr(2'd3, 32'd0);
        xlate(32'h4400_0000, 1'b0, 1'b1, "R4 256 MB window reaches entry 16");

        // R2: reserved bits 7:6 set, attribute 5
        dir_wr(1, 20'h10020, 3'd5, 1'b1, 2'b11);
        xlate(32'h4040_2000, 1'b0, 1'b1, "R2 reserved bits ignored");

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule